// File: doc/BRIEF.md
# Timer Input Capture Unit

This block records the value of a free-running timer count when a chosen edge arrives on a trigger input. The trigger is taken either from an external capture pin or from an analog comparator output, selected by a control bit. The chosen signal passes through a two-flop synchronizer. It then passes through an optional digital noise filter, which needs four equal consecutive samples before its output moves. Last comes an edge detector whose polarity is programmable.

On a detected edge, the count is stored in the capture register and the capture flag is raised in the same clock. The flag drives an interrupt request when interrupts are enabled. The flag clears on an interrupt acknowledge or on a software clear strobe. When the timer uses the capture register as its period limit, a mode input stops all captures and allows the register to be loaded directly.

The capture value is a held register and not a stream. It has no valid/ready handshake and no back-pressure: a later capture simply overwrites it. All control and status pins are plain level or single-cycle strobe signals.

Top module: `tmr_capture`

## Requirements
- R1: On a detected trigger edge, `cap_o` takes the value `cnt_i` had at that clock edge, and `flag_o` is set by the same edge.
- R2: `irq_o` is 1 exactly when `flag_o` is 1 and `irq_en` is 1.
- R3: A one-cycle pulse on `irq_ack` or on `flag_clr` clears `flag_o` at the next edge. If a capture happens in the same cycle, the capture wins and the flag stays set.
- R4: `src_cmp` = 0 selects `pin_i` and `src_cmp` = 1 selects `cmp_i`. The input that is not selected has no effect. Switching the select while the two inputs differ produces a level change that can trigger a capture.
- R5: `rise_sel` = 1 captures on a 0-to-1 change of the conditioned trigger. `rise_sel` = 0 captures on a 1-to-0 change. A change in the other direction leaves `flag_o` and `cap_o` unchanged.
- R6: With `filt_en` = 0, a trigger change set up before clock edge k is captured at edge k+2.
- R7: With `filt_en` = 1, the conditioned level changes only after four consecutive synchronized samples equal the new level. A pulse lasting three clocks causes no capture, and a pulse lasting four clocks does.
- R8: With `filt_en` = 1, the capture happens exactly four clocks later than in R6, at edge k+6.
- R9: While `top_mode` = 1, no capture occurs: `cap_o` keeps its value under trigger activity, and `flag_o` is not set.
- R10: `wr_en` loads `wr_data` into `cap_o` at the next edge only while `top_mode` = 1, without setting `flag_o`. With `top_mode` = 0 the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_i | input | CNT_W | Current timer count |
| pin_i | input | 1 | External capture pin |
| cmp_i | input | 1 | Analog comparator output |
| src_cmp | input | 1 | Trigger source select (1 = comparator) |
| filt_en | input | 1 | Noise filter enable |
| rise_sel | input | 1 | Edge polarity (1 = rising) |
| top_mode | input | 1 | Capture register serves as timer period limit; captures blocked |
| irq_en | input | 1 | Interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge strobe |
| flag_clr | input | 1 | Software flag clear strobe |
| wr_en | input | 1 | Direct write strobe for the capture register |
| wr_data | input | CNT_W | Direct write value |
| cap_o | output | CNT_W | Capture register |
| flag_o | output | 1 | Capture flag |
| irq_o | output | 1 | Interrupt request |

## Verification
A trigger change driven before edge k shows up in `cap_o` and `flag_o` just after edge k+2 without the filter, and just after edge k+6 with it. Clears and direct writes take effect one edge after their strobe. The bench drives every input on the falling edge and notes the count value at that moment. It checks that the flag is still clear just after edge k+1 (or k+5) and set just after edge k+2 (or k+6), comparing against the noted count plus the latency. Checks that expect nothing to happen wait well beyond the longest latency before looking at the outputs.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
  typedef enum logic {
    SRC_PIN = 1'b0,
    SRC_CMP = 1'b1
  } trig_src_e;

  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_pol_e;
endpackage

// File: rtl/tcap_sync.sv
module tcap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/tcap_filter.sv
module tcap_filter #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic d_i,
  output logic q_o
);
  localparam int HW = LEN - 1;

  logic [HW-1:0] hist;
  logic          held;
  logic          all_hi;
  logic          all_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist <= '0;
    else        hist <= {hist[HW-2:0], d_i};
  end

  always_comb begin
    all_hi = d_i;
    all_lo = ~d_i;
    for (int i = 0; i < HW; i++) begin
      all_hi = all_hi & hist[i];
      all_lo = all_lo & ~hist[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      held <= 1'b0;
    else if (all_hi) held <= 1'b1;
    else if (all_lo) held <= 1'b0;
  end

  assign q_o = en_i ? held : d_i;
endmodule

// File: rtl/tcap_edge.sv
module tcap_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic rise_i,
  output logic hit_o
);
  import tcap_pkg::*;

  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= lvl_i;
  end

  always_comb begin
    if (edge_pol_e'(rise_i) == EDGE_RISE) hit_o = lvl_i & ~prev;
    else                                  hit_o = ~lvl_i & prev;
  end
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             pin_i,
  input  logic             cmp_i,
  input  logic             src_cmp,
  input  logic             filt_en,
  input  logic             rise_sel,
  input  logic             top_mode,
  input  logic             irq_en,
  input  logic             irq_ack,
  input  logic             flag_clr,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cap_o,
  output logic             flag_o,
  output logic             irq_o
);
  import tcap_pkg::*;

  logic raw_trig;
  logic sync_lvl;
  logic cond_lvl;
  logic edge_hit;
  logic cap_stb;
  logic [CNT_W-1:0] cap_q;
  logic flag_q;

  assign raw_trig = (trig_src_e'(src_cmp) == SRC_CMP) ? cmp_i : pin_i;

  tcap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw_trig), .q_o(sync_lvl)
  );

  tcap_filter #(.LEN(FILT_LEN)) u_filt (
    .clk(clk), .rst_n(rst_n), .en_i(filt_en), .d_i(sync_lvl), .q_o(cond_lvl)
  );

  tcap_edge u_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(cond_lvl), .rise_i(rise_sel), .hit_o(edge_hit)
  );

  assign cap_stb = edge_hit & ~top_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cap_q <= '0;
    else if (cap_stb)            cap_q <= cnt_i;
    else if (wr_en && top_mode)  cap_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   flag_q <= 1'b0;
    else if (cap_stb)             flag_q <= 1'b1;
    else if (irq_ack || flag_clr) flag_q <= 1'b0;
  end

  assign cap_o  = cap_q;
  assign flag_o = flag_q;
  assign irq_o  = flag_q & irq_en;
endmodule

// File: rtl/tcap_chk.sv
module tcap_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt_i,
  input logic             top_mode,
  input logic             irq_ack,
  input logic             flag_clr,
  input logic             wr_en,
  input logic [CNT_W-1:0] wr_data,
  input logic             cap_stb,
  input logic [CNT_W-1:0] cap_o,
  input logic             flag_o,
  input logic             irq_o
);
  // R1
  cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_stb |=> (cap_o == $past(cnt_i)) && flag_o);

  // R2
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> flag_o);

  // R3
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack || flag_clr) && !cap_stb |=> !flag_o);

  // R9
  top_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    top_mode && !flag_o |=> !flag_o);

  // R10
  wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    top_mode && wr_en |=> cap_o == $past(wr_data));

  // R10
  wr_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !top_mode && !cap_stb |=> $stable(cap_o));
endmodule

bind tmr_capture tcap_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .top_mode(top_mode),
  .irq_ack(irq_ack), .flag_clr(flag_clr), .wr_en(wr_en), .wr_data(wr_data),
  .cap_stb(cap_stb), .cap_o(cap_o), .flag_o(flag_o), .irq_o(irq_o)
);

// File: tb/tmr_capture_test.sv
module tmr_capture_test;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] cnt = '0;
  logic pin_i = 0, cmp_i = 0, src_cmp = 0, filt_en = 0, rise_sel = 1;
  logic top_mode = 0, irq_en = 0, irq_ack = 0, flag_clr = 0, wr_en = 0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] cap_o;
  logic flag_o, irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cnt <= cnt + 16'd1;

  tmr_capture uut (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .pin_i(pin_i), .cmp_i(cmp_i),
    .src_cmp(src_cmp), .filt_en(filt_en), .rise_sel(rise_sel), .top_mode(top_mode),
    .irq_en(irq_en), .irq_ack(irq_ack), .flag_clr(flag_clr), .wr_en(wr_en),
    .wr_data(wr_data), .cap_o(cap_o), .flag_o(flag_o), .irq_o(irq_o)
  );

  // vector: {src_cmp, filt_en, rise_sel, new_level}
  localparam logic [3:0] VEC [8] = '{4'b0011, 4'b0010, 4'b0000, 4'b0111,
                                     4'b0100, 4'b1011, 4'b1110, 4'b1000};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_flag();
    flag_clr = 1; tick(1); flag_clr = 0; tick(1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] c0, old;
    tick(3);
    // R1 reset state
    chk(cap_o == 0 && flag_o == 0 && irq_o == 0, "R1 reset", {cap_o, flag_o}, 0);
    rst_n = 1;
    irq_en = 1;
    tick(2);

    foreach (VEC[v]) begin
      automatic logic s = VEC[v][3];
      automatic logic f = VEC[v][2];
      automatic logic r = VEC[v][1];
      automatic logic t = VEC[v][0];
      automatic bit   hit = (t == r);
      automatic int   lat = f ? 6 : 2;
      src_cmp = s; filt_en = f; rise_sel = r;
      pin_i = ~t; cmp_i = ~t;
      tick(12);
      clear_flag();
      // R3 software clear
      chk(flag_o == 0, "R3 sw clear", flag_o, 0);
      old = cap_o;
      c0 = cnt;
      if (s) cmp_i = t; else pin_i = t;
      tick(lat);
      // R6 / R8 not earlier
      chk(flag_o == 0, f ? "R8 early" : "R6 early", flag_o, 0);
      tick(1);
      // R1 R4 R5 R6 R8 capture value and flag
      chk(flag_o == hit, "R5 flag", flag_o, hit);
      chk(cap_o == (hit ? c0 + W'(lat) : old), f ? "R8 value" : "R6 value",
          cap_o, hit ? c0 + W'(lat) : old);
      // R2 irq follows flag
      chk(irq_o == hit, "R2 irq", irq_o, hit);
      tick(8);
      // R4 unselected input has no effect
      if (s) pin_i = t; else cmp_i = t;
      clear_flag();
      tick(10);
      chk(flag_o == 0, "R4 unselected", flag_o, 0);
    end

    // R2 interrupt disabled
    filt_en = 0; rise_sel = 1; src_cmp = 0; pin_i = 0; cmp_i = 0;
    irq_en = 0;
    tick(8); clear_flag();
    pin_i = 1; tick(8);
    chk(flag_o == 1 && irq_o == 0, "R2 irq masked", irq_o, 0);
    irq_en = 1; tick(1);
    chk(irq_o == 1, "R2 irq enabled", irq_o, 1);

    // R3 acknowledge clears
    irq_ack = 1; tick(1); irq_ack = 0;
    chk(flag_o == 0, "R3 ack clear", flag_o, 0);

    // R3 capture wins over clear
    pin_i = 0; tick(8); clear_flag();
    pin_i = 1; tick(2);
    flag_clr = 1; tick(1); flag_clr = 0;
    chk(flag_o == 1, "R3 set wins", flag_o, 1);

    // R4 source switch causes capture
    pin_i = 1; cmp_i = 0; src_cmp = 0; rise_sel = 0;
    tick(8); clear_flag();
    src_cmp = 1; tick(2);
    chk(flag_o == 0, "R4 switch early", flag_o, 0);
    tick(1);
    chk(flag_o == 1, "R4 switch capture", flag_o, 1);

    // R7 filter glitch rejection
    src_cmp = 0; pin_i = 0; filt_en = 1; rise_sel = 1;
    tick(12); clear_flag();
    old = cap_o;
    pin_i = 1; tick(3); pin_i = 0; tick(12);
    chk(flag_o == 0 && cap_o == old, "R7 3-cycle pulse", flag_o, 0);
    pin_i = 1; tick(4); pin_i = 0; tick(12);
    chk(flag_o == 1, "R7 4-cycle pulse", flag_o, 1);

    // R9 top mode blocks captures
    filt_en = 0; top_mode = 1; tick(4); clear_flag();
    old = cap_o;
    pin_i = 1; tick(8); pin_i = 0; tick(8);
    chk(flag_o == 0 && cap_o == old, "R9 blocked", cap_o, old);

    // R10 write in top mode
    wr_data = 16'hBEEF; wr_en = 1; tick(1); wr_en = 0;
    chk(cap_o == 16'hBEEF && flag_o == 0, "R10 write", cap_o, 16'hBEEF);
    top_mode = 0; tick(2);
    wr_data = 16'h1234; wr_en = 1; tick(1); wr_en = 0; tick(1);
    chk(cap_o == 16'hBEEF, "R10 write ignored", cap_o, 16'hBEEF);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule